// File: doc/BRIEF.md
# Parity-Guarded Byte Substitution Unit

This unit performs the AES byte substitution on a 9-bit word that carries a single parity bit next to its 8 data bits. The parity bit is split off and checked on the way in. The 8 data bits address a 256-entry table. Each table entry holds the substituted byte and a parity bit computed when the table is built. A second checker inspects the 9-bit table word on the way out. When both checks agree, the table word is passed through. When either check fails, a fixed fault word is forced onto the output and an error flag is raised.

The path from input to output is purely combinational, so the unit can drop into a round datapath without adding latency. Odd parity is used everywhere: a valid 9-bit word holds an odd number of ones. For that reason the fault word is itself a valid word, and the error flag is the only thing that separates it from real data. A 9-bit XOR mask sits on the table read path so that a corrupted table cell can be modelled during verification. In normal use the mask is tied to zero.

Top module: `sbox_par_guard`

## Requirements
- R1: Input word layout: bit 8 of `din` is the parity bit and bits 7:0 are the data byte. A word is valid when all nine bits together hold an odd number of ones.
- R2: If `din` holds an even number of ones, `dout` is 9'h001 and `err` is 1, whatever the table returns.
- R3: For every data byte x, the table word has S(x) in bits 7:0 and, in bit 8, the bit that gives the 9-bit word an odd number of ones.
- R4: The table word, XORed with `tbl_flip`, is checked a second time. If it holds an even number of ones, `dout` is 9'h001 and `err` is 1.
- R5: If both the input word and the (masked) table word have odd parity, `dout` equals the masked table word and `err` is 0. Only bits 7:0 of `din` select the table entry.
- R6: The fault word is 9'h001: data bits zero except bit 0, and parity bit 0. `err` is 1 exactly when the fault word is substituted.
- R7: S(x) is the multiplicative inverse of x in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0, followed by the affine map b'i = bi ^ b(i+4)%8 ^ b(i+5)%8 ^ b(i+6)%8 ^ b(i+7)%8 ^ ci, where c = 0x63. Examples: 0x00→0x63, 0x04→0xF2, 0x11→0x82, 0x13→0x7D, 0x15→0x59.
- R8: `dout` always holds an odd number of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 9 | Parity bit (bit 8) and data byte (bits 7:0) |
| tbl_flip | input | 9 | XOR mask on the table read word for fault modelling; tie to zero in use |
| dout | output | 9 | Substituted word with parity, or the fault word 9'h001 |
| err | output | 1 | High when either parity check fails and the fault word is output |

## Verification
The embedded assertions are evaluated whenever the inputs change. They cover four properties: a bad input parity always forces the fault word, a bad table parity always raises the flag, a clear flag always means the table word was forwarded, and the output never carries even parity. Whether the table holds the correct substitution values can only be shown by the bench's scenarios. These compare every byte against an independently computed S-box, flip each of the nine input bits and each of the nine table bits for every byte, and apply double flips that parity cannot catch.

// File: rtl/sbox_par_pkg.sv
// Package: shared widths, constants and the constant functions used to
// build the parity-carrying substitution table at elaboration time.
// Assumes an 8-bit data byte and odd parity over the 9-bit word.
package sbox_par_pkg;

    localparam int DATA_W = 8;
    localparam int WORD_W = DATA_W + 1;
    localparam int DEPTH  = 1 << DATA_W;
    localparam int PAR_B  = DATA_W;              // parity bit index in a word

    localparam logic [DATA_W-1:0] GF_RED   = 8'h1B;  // x^8 = x^4+x^3+x+1
    localparam logic [DATA_W-1:0] AFF_C    = 8'h63;
    localparam logic [WORD_W-1:0] FAULT_WD = 9'h001;

    // Multiply two field elements modulo the AES polynomial.
    function automatic logic [DATA_W-1:0] gf_mul(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] aa;
        logic [DATA_W-1:0] bb;
        logic              hi;
        acc = '0;
        aa  = a;
        bb  = b;
        for (int k = 0; k < DATA_W; k++) begin
            if (bb[0]) acc = acc ^ aa;
            hi = aa[DATA_W-1];
            aa = aa << 1;
            if (hi) aa = aa ^ GF_RED;
            bb = bb >> 1;
        end
        return acc;
    endfunction

    // Inverse as a^254 (square-and-multiply); zero maps to zero.
    function automatic logic [DATA_W-1:0] gf_inv(input logic [DATA_W-1:0] a);
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] ex;
        res  = 8'h01;
        base = a;
        ex   = 8'hFE;
        for (int k = 0; k < DATA_W; k++) begin
            if (ex[k]) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        return res;
    endfunction

    // Affine output map over GF(2).
    function automatic logic [DATA_W-1:0] aff_map(input logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] o;
        for (int i = 0; i < DATA_W; i++) begin
            o[i] = b[i] ^ b[(i+4)%DATA_W] ^ b[(i+5)%DATA_W]
                 ^ b[(i+6)%DATA_W] ^ b[(i+7)%DATA_W] ^ AFF_C[i];
        end
        return o;
    endfunction

    // Full substitution of one byte.
    function automatic logic [DATA_W-1:0] subst(input logic [DATA_W-1:0] x);
        return aff_map(gf_inv(x));
    endfunction

    // Bit that makes {bit, d} hold an odd number of ones.
    function automatic logic odd_bit(input logic [DATA_W-1:0] d);
        return ~(^d);
    endfunction

endpackage

// File: rtl/sbox_par_checker.sv
// Odd-parity checker: flags a word whose ones count is odd as good.
// Assumes nothing about which bit is the parity bit; it checks the whole word.
module sbox_par_checker #(
    parameter int W = 9
) (
    input  logic [W-1:0] word,
    output logic         good
);

    // Reduction XOR is 1 for an odd number of ones.
    always_comb begin
        good = ^word;
    end

endmodule

// File: rtl/sbox_par_table.sv
// Substitution table: DEPTH entries, each the substituted byte with its
// stored odd-parity bit in the top position. Contents are computed at
// elaboration from the field functions; the read is combinational.
module sbox_par_table
    import sbox_par_pkg::*;
(
    input  logic [DATA_W-1:0] addr,
    output logic [WORD_W-1:0] word
);

    logic [WORD_W-1:0] cells [DEPTH];

    // One constant cell per address, computed from the field arithmetic.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        localparam logic [DATA_W-1:0] SB = subst(DATA_W'(gi));
        assign cells[gi] = {odd_bit(SB), SB};
    end

    // Read port: address picks the stored word.
    always_comb begin
        word = cells[addr];
    end

    // Every stored word leaves the table with odd parity (R3).
    always_comb begin
        p_entry_odd_r3: assert (^word == 1'b1)
            else $error("table word %h has even parity", word);
    end

endmodule

// File: rtl/sbox_par_guard.sv
// Top: parity-guarded byte substitution. Checks input parity, looks up the
// data byte, checks the table word (after the fault-model mask), and either
// forwards the table word or forces the fault word with err high.
// Assumes tbl_flip is zero outside fault-injection testing.
module sbox_par_guard
    import sbox_par_pkg::*;
(
    input  logic [WORD_W-1:0] din,
    input  logic [WORD_W-1:0] tbl_flip,
    output logic [WORD_W-1:0] dout,
    output logic              err
);

    logic [DATA_W-1:0] in_data;
    logic              in_good;
    logic [WORD_W-1:0] raw_word;
    logic [WORD_W-1:0] tbl_word;
    logic              tbl_good;

    // Split the data byte away from its parity bit.
    always_comb begin
        in_data = din[DATA_W-1:0];
    end

    sbox_par_checker #(.W(WORD_W)) u_in_chk (
        .word (din),
        .good (in_good)
    );

    sbox_par_table u_table (
        .addr (in_data),
        .word (raw_word)
    );

    // Apply the fault-model mask on the table read path.
    always_comb begin
        tbl_word = raw_word ^ tbl_flip;
    end

    sbox_par_checker #(.W(WORD_W)) u_out_chk (
        .word (tbl_word),
        .good (tbl_good)
    );

    // Forward on double pass, otherwise force the fault word.
    always_comb begin
        if (in_good && tbl_good) begin
            dout = tbl_word;
            err  = 1'b0;
        end else begin
            dout = FAULT_WD;
            err  = 1'b1;
        end
    end

    // Guard assertions on the output selection.
    always_comb begin
        if (^din == 1'b0) begin
            p_in_fault_r2: assert (err && dout == FAULT_WD)
                else $error("bad input parity not trapped");
        end
        if (^tbl_word == 1'b0) begin
            p_tbl_fault_r4: assert (err)
                else $error("bad table parity not flagged");
        end
        if (!err) begin
            p_pass_word_r5: assert (dout == tbl_word)
                else $error("clean result not forwarded");
        end
        p_out_odd_r8: assert (^dout == 1'b1)
            else $error("output with even parity");
    end

endmodule

// File: tb/sbox_par_guard_bench.sv
// Scoreboard bench: the driver computes expected words from an independent
// brute-force S-box model and queues them; the monitor compares on the
// falling edge, one item per cycle.
module sbox_par_guard_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] din = 9'h000;
    logic [8:0] tbl_flip = 9'h000;
    logic [8:0] dout;
    logic       err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] ref_tab [256];

    always #10 clk = ~clk;   // 50 MHz

    sbox_par_guard u_sbox_par_guard (
        .din      (din),
        .tbl_flip (tbl_flip),
        .dout     (dout),
        .err      (err)
    );

    function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] rsub(input logic [7:0] x);
        logic [7:0] inv;
        logic [7:0] o;
        logic [7:0] c;
        inv = 8'h00;
        c   = 8'h63;
        for (int b = 1; b < 256; b++) if (rmul(x, 8'(b)) == 8'h01) inv = 8'(b);
        for (int i = 0; i < 8; i++)
            o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                 ^ inv[(i+7)%8] ^ c[i];
        return o;
    endfunction

    function automatic logic [9:0] model(input logic [8:0] d, input logic [8:0] f);
        logic [7:0] s;
        logic [8:0] t;
        s = ref_tab[d[7:0]];
        t = {~(^s), s} ^ f;
        if ((^d) && (^t)) return {t, 1'b0};
        return {9'h001, 1'b1};
    endfunction

    function automatic logic [8:0] mkword(input logic [7:0] d);
        return {~(^d), d};
    endfunction

    task automatic drive_exp(input logic [8:0] d, input logic [8:0] f,
                             input logic [9:0] e, input string tag);
        @(posedge clk);
        #1;
        din      = d;
        tbl_flip = f;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic drive(input logic [8:0] d, input logic [8:0] f, input string tag);
        drive_exp(d, f, model(d, f), tag);
    endtask

    // Monitor: pop one expected item per cycle and compare.
    always @(negedge clk) begin
        if (rst_n && exp_q.size() > 0) begin
            logic [9:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({dout, err} !== e) begin
                errors++;
                $display("FAIL %s: dout=%h err=%b expected dout=%h err=%b",
                         t, dout, err, e[9:1], e[0]);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_tab[i] = rsub(8'(i));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R2/R6: idle all-zero input has even parity -> fault word.
        drive_exp(9'h000, 9'h000, {9'h001, 1'b1}, "R2 idle zero");

        // R7: known mappings with explicit expected values.
        drive_exp(mkword(8'h00), 9'h0, {1'b1, 8'h63, 1'b0}, "R7 00->63");
        drive_exp(mkword(8'h04), 9'h0, {1'b0, 8'hF2, 1'b0}, "R7 04->F2");
        drive_exp(mkword(8'h11), 9'h0, {1'b1, 8'h82, 1'b0}, "R7 11->82");
        drive_exp(mkword(8'h13), 9'h0, {1'b1, 8'h7D, 1'b0}, "R7 13->7D");
        drive_exp(mkword(8'h15), 9'h0, {1'b1, 8'h59, 1'b0}, "R7 15->59");

        // R3/R5/R1: every byte, correct parity, clean table.
        for (int x = 0; x < 256; x++) drive(mkword(8'(x)), 9'h0, "R3 R5 sweep");

        // R2: every single input bit flip must trap.
        for (int x = 0; x < 256; x++)
            for (int b = 0; b < 9; b++)
                drive_exp(mkword(8'(x)) ^ (9'h1 << b), 9'h0, {9'h001, 1'b1},
                          "R2 input flip");

        // R4: every single table bit flip must trap.
        for (int x = 0; x < 256; x++)
            for (int b = 0; b < 9; b++)
                drive_exp(mkword(8'(x)), 9'h1 << b, {9'h001, 1'b1},
                          "R4 table flip");

        // R5: double input flips pass parity; lookup uses only bits 7:0.
        for (int x = 0; x < 256; x += 17)
            drive(mkword(8'(x)) ^ 9'h101, 9'h0, "R5 double input flip");

        // R4/R5: double table flips escape and are forwarded as stored.
        for (int x = 0; x < 256; x += 13)
            drive(mkword(8'(x)), 9'h003, "R5 double table flip");

        // R6/R8: both checks failing together still gives one fault word.
        drive_exp(mkword(8'h5A) ^ 9'h004, 9'h080, {9'h001, 1'b1}, "R6 both fail");

        repeat (3) @(posedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: %0d items left, expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule